// File: doc/BRIEF.md
# NMI Source Vector Accumulator

This block sits in an interrupt controller and gathers the sources of pending non-maskable interrupts. Each incoming NMI message brings an 8-bit source vector. The block turns that vector into one bit of a pending-source mask. Bits keep piling up across messages until the processor takes the NMI. Software can then poll only the flagged sources. Bit 0 means "source unknown, poll every handler".

A vector that is zero, or that is at or above the mask width, lands on bit 0. A local external NMI pin can also raise an NMI. Its source vector is held in a register that software writes. Only a rising edge on the pin counts, so a level held high gives one event.

When the processor takes the NMI, the consumer samples the mask during a delivery strobe. The mask clears in that same cycle. A message that arrives in the delivery cycle goes into the freshly cleared mask, so it is not lost.

Top module: `nmi_src_accum`

## Requirements
- R1: A message with `msg_valid` high and `msg_vector` v below NUM_SRC (16 by default) sets bit v of `src_mask` in the following cycle.
- R2: A message with vector 0 sets bit 0 in the following cycle.
- R3: A message with vector NUM_SRC or higher, up to 255, sets bit 0 in the following cycle and sets no other bit.
- R4: Without a delivery strobe, no set bit ever clears, so bits from successive messages accumulate.
- R5: While `deliver` is high, `src_mask` still shows the accumulated value. In the next cycle, every bit not newly set in the delivery cycle is zero.
- R6: A message or pin event in the same cycle as `deliver` appears in the mask of the following cycle.
- R7: A rising edge on `lint_nmi` sets the mask bit chosen by the programmed pin vector, folding by the R1 to R3 rules. Holding the pin high for further cycles sets nothing more. A vector written with `lint_cfg_we` applies to edges in later cycles.
- R8: `nmi_pending` is high exactly when any bit of `src_mask` is set.
- R9: A synchronous active-high `rst` clears the mask, the edge detector and the pin vector. A pin edge after reset therefore sets bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | An NMI message is present this cycle |
| msg_vector | input | 8 | Source vector of the message |
| lint_cfg_we | input | 1 | Write strobe for the pin source vector |
| lint_cfg_vector | input | 8 | New pin source vector |
| lint_nmi | input | 1 | Local external NMI pin |
| deliver | input | 1 | NMI taken: the mask is sampled now and cleared |
| src_mask | output | NUM_SRC | Accumulated pending-source mask |
| nmi_pending | output | 1 | Some source is pending |

## Verification
The bench first sends single in-range vectors at the low, middle and top bits, then vector 0. Out-of-range vectors just above the width and at 255 confirm that folding goes to bit 0 alone. Runs of messages without delivery separate true accumulation from overwriting. Delivery alone is set against delivery with a simultaneous message or pin edge, which shows the clear does not swallow arrivals. The pin is pulsed, held high, and reprogrammed to in-range and out-of-range vectors. It is also pulsed right after reset, which shows the reset value of its vector.

// File: rtl/nmi_src_accum.sv
module nmi_src_accum #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msg_valid,
  input  logic [7:0]         msg_vector,
  input  logic               lint_cfg_we,
  input  logic [7:0]         lint_cfg_vector,
  input  logic               lint_nmi,
  input  logic               deliver,
  output logic [NUM_SRC-1:0] src_mask,
  output logic               nmi_pending
);
  localparam int VEC_W = 8;
  localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

  logic [NUM_SRC-1:0] mask_q, msg_bit, lint_bit;
  logic [VEC_W-1:0]   lint_vec_q;
  logic               lint_q;
  logic               lint_edge;

  function automatic logic [NUM_SRC-1:0] fold(input logic [VEC_W-1:0] v);
    if (int'(v) < NUM_SRC) fold = ONE << v;
    else                   fold = ONE;
  endfunction

  assign lint_edge   = lint_nmi & ~lint_q;
  assign msg_bit     = msg_valid ? fold(msg_vector) : '0;
  assign lint_bit    = lint_edge ? fold(lint_vec_q) : '0;
  assign src_mask    = mask_q;
  assign nmi_pending = |mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      lint_q     <= 1'b0;
      lint_vec_q <= '0;
    end else begin
      mask_q <= (deliver ? '0 : mask_q) | msg_bit | lint_bit;
      lint_q <= lint_nmi;
      if (lint_cfg_we) lint_vec_q <= lint_cfg_vector;
    end
  end

  p_set_r1: assert property (@(posedge clk) disable iff (rst)
    msg_valid && int'(msg_vector) < NUM_SRC |=>
      ((src_mask >> $past(msg_vector)) & ONE) != '0);

  p_fold_r3: assert property (@(posedge clk) disable iff (rst)
    msg_valid && int'(msg_vector) >= NUM_SRC |=> src_mask[0]);

  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !deliver |=> (src_mask & $past(src_mask)) == $past(src_mask));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    deliver && !msg_valid && !lint_nmi |=> src_mask == '0);

  p_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> src_mask == '0);
endmodule

// File: tb/tb_nmi_src_accum.sv
module tb_nmi_src_accum;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_valid = 1'b0, lint_cfg_we = 1'b0, lint_nmi = 1'b0, deliver = 1'b0;
  logic [7:0] msg_vector = '0, lint_cfg_vector = '0;
  logic [N-1:0] src_mask;
  logic nmi_pending;

  int compared = 0, mismatched = 0;
  logic [N-1:0] m_mask = '0;
  logic m_prev = 1'b0;
  logic [7:0] m_vec = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_src_accum #(.NUM_SRC(N)) dut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .lint_cfg_we(lint_cfg_we), .lint_cfg_vector(lint_cfg_vector),
    .lint_nmi(lint_nmi), .deliver(deliver),
    .src_mask(src_mask), .nmi_pending(nmi_pending));

  function automatic logic [N-1:0] bit_of(input int v);
    if (v < N) return N'(1) << v;
    return N'(1);
  endfunction

  task automatic check(input string tag);
    compared++;
    if (src_mask !== m_mask || nmi_pending !== (m_mask != 0)) begin
      mismatched++;
      $display("FAIL %s: mask=%h pending=%b expected mask=%h pending=%b",
               tag, src_mask, nmi_pending, m_mask, m_mask != 0);
    end
  endtask

  task automatic step(input logic mv, input int vec, input logic we, input int cv,
                      input logic li, input logic dl, input logic rs, input string tag);
    logic [N-1:0] nm;
    logic [7:0] nv;
    logic np;
    msg_valid = mv; msg_vector = 8'(vec); lint_cfg_we = we; lint_cfg_vector = 8'(cv);
    lint_nmi = li; deliver = dl; rst = rs;
    if (rs) begin
      nm = '0; np = 1'b0; nv = '0;
    end else begin
      nm = dl ? '0 : m_mask;
      if (mv) nm |= bit_of(vec);
      if (li && !m_prev) nm |= bit_of(int'(m_vec));
      np = li;
      nv = we ? 8'(cv) : m_vec;
    end
    @(posedge clk);
    m_mask = nm; m_prev = np; m_vec = nv;
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, lint_nmi, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 1, "R9");
    idle("R9");
    step(1, 1, 0, 0, 0, 0, 0, "R1");
    step(1, 5, 0, 0, 0, 0, 0, "R1");
    step(1, 15, 0, 0, 0, 0, 0, "R1");
    idle("R4");
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    idle("R8");
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    step(1, 16, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    step(1, 255, 0, 0, 0, 0, 0, "R3");
    step(1, 9, 0, 0, 0, 1, 0, "R6");
    step(1, 3, 0, 0, 0, 0, 0, "R4");
    step(1, 3, 0, 0, 0, 0, 0, "R4");
    step(1, 12, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 1, 0, "R5");
    step(0, 0, 1, 2, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 0, 0, "R7");
    for (int i = 0; i < 3; i++) idle("R7");
    step(0, 0, 0, 0, 1, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 40, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 1, 0, 0, "R7");
    step(1, 7, 1, 11, 0, 1, 0, "R6");
    step(1, 4, 0, 0, 1, 1, 0, "R6");
    step(1, 6, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 1, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 0, "R8");
    for (int i = 0; i < 40; i++)
      step((i % 3) != 0, (i * 37) % 64, (i % 7) == 0, (i * 5) % 20,
           (i % 4) < 2, (i % 5) == 0, 0, "R4");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule